// File: doc/BRIEF.md
# Multi-Lane Alignment Deskew Buffer

This block takes a group of two, three or four byte lanes that were split from one stream and then travelled over paths of different lengths. It lines them up again. Each lane carries an alignment character at regular intervals. The block looks for that character on every lane of the group, measures how far each lane runs ahead of the latest one, and holds back the early lanes by that many bytes. From then on, markers that were sent together leave the block on the same clock cycle.

The alignment character and the group size are inputs. The spread between the first and the last marker of one round may be at most four bytes. A wider spread raises a one-cycle error and starts the search again. Once the lanes are aligned, the block keeps checking the markers at its output. If some lanes of the group show a marker and others do not, it drops the aligned flag and searches again.

Top module: `lane_deskew`

## Requirements
- R1: `grp_size` values 2, 3 and 4 select lanes 0..n-1 as the group. Any other value selects all four lanes. A lane outside the group drives `out_data` byte 0 and `out_vld` 0, and its markers have no effect on alignment or on errors.
- R2: A marker is a lane byte whose valid bit is high and whose value equals `align_char`. The character can be changed between runs.
- R3: While searching, the search window opens on the first grouped marker. If every grouped lane shows a marker no later than four cycles after that first one, `aligned` goes high on the clock edge that captures the last of those markers.
- R4: Once aligned, lane l is delayed by (latest marker arrival minus lane l's marker arrival) extra cycles. From the second aligned cycle on, grouped output lanes show markers either all together or not at all.
- R5: If the window reaches its fifth cycle without markers from every grouped lane, `skew_err` is high for exactly one cycle, `aligned` stays low, and the search starts over.
- R6: While aligned, if the selected taps show a marker on some grouped lanes but not on all, `aligned` falls on the same edge that outputs those bytes. The extra delays return to zero and the search restarts.
- R7: While `rst` is high, `aligned`, `skew_err`, `out_vld` and `out_data` are all zero, and the delay history is cleared.
- R8: While not aligned, each grouped lane passes through with one cycle of latency and no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_data | input | 32 | Lane bytes, lane l in bits 8l+7..8l |
| lane_vld | input | 4 | Per-lane byte valid |
| grp_size | input | 3 | Number of grouped lanes (2, 3, 4; other values select 4) |
| align_char | input | 8 | Alignment character |
| out_data | output | 32 | Deskewed lane bytes |
| out_vld | output | 4 | Valid bits delayed together with the data |
| aligned | output | 1 | Lanes are aligned |
| skew_err | output | 1 | One-cycle pulse when the search window expires |

## Verification
Two events can share the last cycle of the search window: the last lane's marker arriving, which completes the alignment, and the window expiring. Random skews of zero to four bytes place that late marker on every window position up to and including the last one, where completion must win. A skew of five puts it one byte beyond, where the error must fire instead. The second pair is lock loss and fresh input markers: one lane's delay is bumped while aligned, so that the partial marker at the output and new markers at the input meet in the same cycle. A behavioural model checks every cycle of both pairs.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } dsk_state_e;

  // number of lanes in the group for a requested size
  function automatic int eff_lanes(input int lanes, input int req);
    if (req >= 2 && req <= lanes) return req;
    return lanes;
  endfunction

endpackage

// File: rtl/deskew_delay_line.sv
module deskew_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 5,
  parameter int TAPW  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    din,
  input  logic            vin,
  input  logic [TAPW-1:0] sel,
  output logic [W-1:0]    tap_d,
  output logic            tap_v
);

  logic [W-1:0]     d_q [1:DEPTH-1];
  logic [DEPTH-1:1] v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      for (int k = 1; k < DEPTH; k++) d_q[k] <= '0;
    end else begin
      d_q[1] <= din;
      v_q[1] <= vin;
      for (int k = 2; k < DEPTH; k++) begin
        d_q[k] <= d_q[k-1];
        v_q[k] <= v_q[k-1];
      end
    end
  end

  always_comb begin
    tap_d = din;
    tap_v = vin;
    for (int k = 1; k < DEPTH; k++) begin
      if (sel == TAPW'(k)) begin
        tap_d = d_q[k];
        tap_v = v_q[k];
      end
    end
  end

endmodule

// File: rtl/deskew_search.sv
module deskew_search #(
  parameter int LANES    = 4,
  parameter int MAX_SKEW = 4,
  parameter int TAPW     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run,
  input  logic                       clear,
  input  logic [LANES-1:0]           hit,
  input  logic [LANES-1:0]           grp,
  output logic                       done,
  output logic                       expire,
  output logic [LANES-1:0][TAPW-1:0] sel
);

  logic [LANES-1:0]           seen_q, seen_n, fresh;
  logic [LANES-1:0][TAPW-1:0] age_q, age_n;
  logic                       active_q, active_n;
  logic [TAPW-1:0]            cnt_q, cnt_n;

  always_comb begin
    seen_n   = seen_q;
    age_n    = age_q;
    active_n = active_q;
    cnt_n    = cnt_q;
    if (active_q) begin
      cnt_n = cnt_q + TAPW'(1);
      for (int l = 0; l < LANES; l++)
        if (seen_q[l]) age_n[l] = age_q[l] + TAPW'(1);
    end
    fresh  = hit & grp & ~seen_q;
    seen_n = seen_q | fresh;
    for (int l = 0; l < LANES; l++)
      if (fresh[l]) age_n[l] = '0;
    if (fresh != '0 && !active_q) begin
      active_n = 1'b1;
      cnt_n    = '0;
    end
    done   = run && (grp != '0) && ((seen_n & grp) == grp);
    expire = run && !done && active_n && (cnt_n == TAPW'(MAX_SKEW));
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen_q   <= '0;
      age_q    <= '0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      sel      <= '0;
    end else if (run) begin
      if (done || expire) begin
        seen_q   <= '0;
        age_q    <= '0;
        active_q <= 1'b0;
        cnt_q    <= '0;
        if (done) sel <= age_n;
      end else begin
        seen_q   <= seen_n;
        age_q    <= age_n;
        active_q <= active_n;
        cnt_q    <= cnt_n;
      end
    end
  end

  // R5: an open window never outlives its limit
  a_r5_window_bound: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (cnt_q < TAPW'(MAX_SKEW)));

  // R3: a window that is open has at least one lane seen
  a_r3_window_has_lane: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (seen_q != '0));

endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
  import lane_deskew_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int W        = 8,
  parameter int MAX_SKEW = 4,
  localparam int DEPTH   = MAX_SKEW + 1,
  localparam int TAPW    = $clog2(DEPTH),
  localparam int CW      = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*W-1:0] lane_data,
  input  logic [LANES-1:0]   lane_vld,
  input  logic [CW-1:0]      grp_size,
  input  logic [W-1:0]       align_char,
  output logic [LANES*W-1:0] out_data,
  output logic [LANES-1:0]   out_vld,
  output logic               aligned,
  output logic               skew_err
);

  dsk_state_e                 state_q;
  logic [LANES-1:0]           grp, cur_hit, tap_hit, tap_v;
  logic [LANES-1:0][W-1:0]    tap_d;
  logic [LANES-1:0][TAPW-1:0] sel;
  logic                       done, expire, mis, run;

  always_comb begin
    for (int l = 0; l < LANES; l++)
      grp[l] = (l < eff_lanes(LANES, int'(grp_size)));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    deskew_delay_line #(.W(W), .DEPTH(DEPTH), .TAPW(TAPW)) u_line (
      .clk   (clk),
      .rst   (rst),
      .din   (lane_data[l*W +: W]),
      .vin   (lane_vld[l]),
      .sel   (sel[l]),
      .tap_d (tap_d[l]),
      .tap_v (tap_v[l])
    );
    assign cur_hit[l] = lane_vld[l] && (lane_data[l*W +: W] == align_char);
    assign tap_hit[l] = tap_v[l] && (tap_d[l] == align_char);
  end

  assign run = (state_q == ST_SEARCH);
  assign mis = (state_q == ST_LOCKED) && ((tap_hit & grp) != '0)
               && ((tap_hit & grp) != grp);

  deskew_search #(.LANES(LANES), .MAX_SKEW(MAX_SKEW), .TAPW(TAPW)) u_search (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .clear  (mis),
    .hit    (cur_hit & grp),
    .grp    (grp),
    .done   (done),
    .expire (expire),
    .sel    (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_SEARCH;
      skew_err <= 1'b0;
      out_data <= '0;
      out_vld  <= '0;
    end else begin
      skew_err <= expire;
      if (mis) state_q <= ST_SEARCH;
      else if (done) state_q <= ST_LOCKED;
      for (int l = 0; l < LANES; l++) begin
        out_data[l*W +: W] <= grp[l] ? tap_d[l] : '0;
        out_vld[l]         <= grp[l] && tap_v[l];
      end
    end
  end

  assign aligned = (state_q == ST_LOCKED);

  // assertion helpers: grouped markers at the output
  logic [LANES-1:0] out_mk;
  always_comb begin
    for (int l = 0; l < LANES; l++)
      out_mk[l] = grp[l] && out_vld[l] && (out_data[l*W +: W] == align_char);
  end

  // R4: steady lock shows grouped markers all together or not at all
  a_r4_markers_together: assert property (@(posedge clk) disable iff (rst)
    (aligned && $past(aligned) && $stable(grp_size) && $stable(align_char))
      |-> (out_mk == '0 || out_mk == grp));

  // R6: a fall of the lock is always caused by a partial marker set
  a_r6_fall_on_partial: assert property (@(posedge clk) disable iff (rst)
    ($fell(aligned) && $stable(grp_size) && $stable(align_char))
      |-> (out_mk != '0 && out_mk != grp));

  // R5: error is a single-cycle pulse and never coincides with lock
  a_r5_err_pulse: assert property (@(posedge clk) disable iff (rst)
    skew_err |=> !skew_err);
  a_r5_err_unlocked: assert property (@(posedge clk) disable iff (rst)
    skew_err |-> !aligned);

  // R1: lanes outside the group stay quiet
  a_r1_outside_quiet: assert property (@(posedge clk) disable iff (rst)
    $stable(grp_size) |-> ((out_vld & ~grp) == '0));

endmodule

// File: tb/test_lane_deskew.sv
module test_lane_deskew;
  localparam int L = 4;
  localparam int W = 8;
  localparam int MS = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [L*W-1:0] lane_data = '0;
  logic [L-1:0] lane_vld = '0;
  logic [2:0]   grp_size = 3'd4;
  logic [W-1:0] align_char = 8'hBC;
  logic [L*W-1:0] out_data;
  logic [L-1:0] out_vld;
  logic         aligned, skew_err;

  lane_deskew i_lane_deskew (
    .clk(clk), .rst(rst), .lane_data(lane_data), .lane_vld(lane_vld),
    .grp_size(grp_size), .align_char(align_char), .out_data(out_data),
    .out_vld(out_vld), .aligned(aligned), .skew_err(skew_err));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int sk[L];
  int tcur = 0;
  bit saw_err, saw_fall, prev_al;

  // reference model state
  int         m_sel[L], m_age[L], m_cnt;
  bit         m_seen[L], m_active, m_aligned, m_err;
  logic [7:0] m_od[L];
  bit         m_ov[L];
  logic [7:0] qd[L][$];
  bit         qv[L][$];

  function automatic int n_grp();
    return (grp_size >= 2 && grp_size <= 4) ? int'(grp_size) : 4;
  endfunction

  function automatic logic [7:0] srcb(int t, int l);
    logic [7:0] b;
    if (t % 12 == 0) return align_char;
    b = 8'((t * 29 + l * 71 + 5) & 255);
    if (b == align_char) b = b ^ 8'h01;
    return b;
  endfunction

  task automatic m_clear();
    for (int l = 0; l < L; l++) begin m_seen[l] = 0; m_age[l] = 0; end
    m_active = 0; m_cnt = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_clear();
      m_aligned = 0; m_err = 0;
      for (int l = 0; l < L; l++) begin
        m_sel[l] = 0; m_od[l] = 0; m_ov[l] = 0;
        qd[l] = {8'h0, 8'h0, 8'h0, 8'h0};
        qv[l] = {1'b0, 1'b0, 1'b0, 1'b0};
      end
    end else begin
      int n, hits, nseen;
      logic [7:0] td[L];
      bit tv[L], newh[L], anynew;
      n = n_grp();
      for (int l = 0; l < L; l++) begin
        td[l] = (m_sel[l] == 0) ? lane_data[l*W +: W] : qd[l][m_sel[l]-1];
        tv[l] = (m_sel[l] == 0) ? lane_vld[l] : qv[l][m_sel[l]-1];
        m_od[l] = (l < n) ? td[l] : 8'h0;
        m_ov[l] = (l < n) && tv[l];
      end
      m_err = 0;
      if (m_aligned) begin
        hits = 0;
        for (int l = 0; l < n; l++) if (tv[l] && td[l] == align_char) hits++;
        if (hits > 0 && hits < n) begin
          m_aligned = 0; m_clear();
          for (int l = 0; l < L; l++) m_sel[l] = 0;
        end
      end else begin
        if (m_active) begin
          m_cnt++;
          for (int l = 0; l < L; l++) if (m_seen[l]) m_age[l]++;
        end
        anynew = 0;
        for (int l = 0; l < n; l++) begin
          newh[l] = lane_vld[l] && lane_data[l*W +: W] == align_char && !m_seen[l];
          if (newh[l]) begin m_seen[l] = 1; m_age[l] = 0; anynew = 1; end
        end
        if (anynew && !m_active) begin m_active = 1; m_cnt = 0; end
        nseen = 0;
        for (int l = 0; l < n; l++) if (m_seen[l]) nseen++;
        if (nseen == n) begin
          m_aligned = 1;
          for (int l = 0; l < L; l++) m_sel[l] = m_age[l];
          m_clear();
        end else if (m_active && m_cnt == MS) begin
          m_err = 1; m_clear();
        end
      end
      for (int l = 0; l < L; l++) begin
        qd[l].push_front(lane_data[l*W +: W]); void'(qd[l].pop_back());
        qv[l].push_front(lane_vld[l]);         void'(qv[l].pop_back());
      end
    end
  end

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [L*W-1:0] ed;
    logic [L-1:0] ev;
    int n, mk;
    for (int l = 0; l < L; l++) begin ed[l*W +: W] = m_od[l]; ev[l] = m_ov[l]; end
    check(out_data == ed && out_vld == ev && aligned == m_aligned && skew_err == m_err,
          m_aligned ? "R4" : "R8", "cycle model",
          {out_vld, aligned, skew_err, out_data[25:0]}, {ev, m_aligned, m_err, ed[25:0]});
    if (!rst && aligned && prev_al) begin
      n = n_grp(); mk = 0;
      for (int l = 0; l < n; l++) if (out_vld[l] && out_data[l*W +: W] == align_char) mk++;
      check(mk == 0 || mk == n, "R4", "grouped markers together", mk, n);
    end
    if (skew_err) saw_err = 1;
    if (prev_al && !aligned) saw_fall = 1;
    prev_al = aligned;
  endtask

  task automatic cycle();
    @(negedge clk);
    compare();
    for (int l = 0; l < L; l++) begin
      int s = tcur - sk[l];
      lane_vld[l] = (s >= 0);
      lane_data[l*W +: W] = (s >= 0) ? srcb(s, l) : 8'h0;
    end
    tcur++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; lane_vld = '0; lane_data = '0;
    repeat (3) cycle();
    @(negedge clk);
    rst = 0; tcur = 0; saw_err = 0; saw_fall = 0; prev_al = 0;
    for (int l = 0; l < L; l++) lane_vld[l] = 0;
  endtask

  task automatic run_trial(int g, int cyc, string req);
    grp_size = 3'(g);
    do_reset();
    repeat (cyc) cycle();
    check(aligned == 1'b1, req, "aligned after search", aligned, 1);
    check(saw_err == 0, req, "no skew error", saw_err, 0);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int l = 0; l < L; l++) sk[l] = 0;
    repeat (2) @(negedge clk);
    // R7: reset state
    check(aligned == 0 && skew_err == 0, "R7", "flags in reset", {aligned, skew_err}, 0);
    check(out_vld == 0 && out_data == 0, "R7", "outputs in reset", out_data, 0);

    // R3 / R4: random skews 0..4 on a full group
    for (int trial = 0; trial < 8; trial++) begin
      for (int l = 0; l < L; l++) sk[l] = $urandom_range(MS, 0);
      if (trial == 0) begin sk[0] = 0; sk[1] = 4; sk[2] = 2; sk[3] = 4; end
      run_trial(4, 50, "R3");
    end

    // R1: group of 3, lane 3 far out of range
    sk[0] = 2; sk[1] = 0; sk[2] = 4; sk[3] = 9;
    run_trial(3, 50, "R1");
    check(out_vld[3] == 0 && out_data[31:24] == 0, "R1", "lane 3 outside group", out_data[31:24], 0);

    // R2: other character, group of 2
    align_char = 8'h7C;
    sk[0] = 3; sk[1] = 0; sk[2] = 7; sk[3] = 11;
    run_trial(2, 50, "R2");
    check(out_vld[3:2] == 0, "R1", "lanes 2,3 outside group of 2", out_vld, 4'b0011);

    // R1: out-of-range size selects all lanes
    sk[0] = 1; sk[1] = 1; sk[2] = 0; sk[3] = 3;
    run_trial(0, 50, "R1");
    check(out_vld == 4'hF, "R1", "size 0 groups all lanes", out_vld, 4'hF);
    align_char = 8'hBC;

    // R5: skew of five
    sk[0] = 0; sk[1] = 5; sk[2] = 1; sk[3] = 2;
    grp_size = 3'd4;
    do_reset();
    repeat (60) cycle();
    check(saw_err == 1, "R5", "error on skew 5", saw_err, 1);
    check(aligned == 0, "R5", "never aligned on skew 5", aligned, 0);

    // R6: lock loss after a delay change, then recovery
    sk[0] = 1; sk[1] = 3; sk[2] = 0; sk[3] = 2;
    run_trial(4, 40, "R6");
    sk[0] = 2;
    repeat (50) cycle();
    check(saw_fall == 1, "R6", "lock dropped on partial marker", saw_fall, 1);
    check(aligned == 1, "R6", "relocked after change", aligned, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule